// File: doc/BRIEF.md
# Parallel Display Read-Data Packer

This block sits behind the strobe generator of a 6800/8080-style parallel display port. It receives the subword returned on each read strobe, 8 or 16 bits wide, and builds 32-bit words for a receive FIFO. At the start of each read transaction, it drops a programmed number of leading dummy subwords. This covers display controllers whose first read returns stale data. Each kept subword can be shifted by a programmed amount in either direction. The kept subwords are then packed from byte 0 upward until a programmed subword count is reached or all four bytes are filled.

Once a word is complete, an optional swap reverses the byte order among the valid bytes only. An optional pixel mode then reads the word as RGB565, RGB666 or RGB888, expands it to 8 bits per channel, and re-encodes it as 16, 18 or 24 bits per pixel. An end-of-transaction pulse pushes out a partly filled word. The result leaves on a valid/ready output. While that output is stalled, a busy flag tells the strobe generator to hold off.

Top module: `lcd_rd_packer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` and `busy` are 0.
- R2: A `start` pulse loads `cfg_dummy`. The next `cfg_dummy` accepted subwords are discarded. Later words in the same transaction are not discarded again.
- R3: Kept subwords fill the word from byte 0 upward, in arrival order. In 8-bit mode (`cfg_bus16`=0), only `rd_data[7:0]` is used. A word completes after `cfg_pack_cnt` subwords (0 counts as 1) or when 4 bytes are filled. `out_bytes` gives the number of valid bytes.
- R4: Each subword is shifted by `cfg_shift_amt` bits before it is packed. The shift is left when `cfg_shift_left`=1 and right otherwise, and the result is truncated to the subword width.
- R5: With `cfg_swap`=1, the valid bytes are reversed: byte i takes byte (n-1-i), where n is the number of valid bytes. Bytes at or above n take no part in the swap.
- R6: With pixel mode off, output bytes at or above the valid count are 0.
- R7: With `cfg_rgb`=1, the swapped word is read according to `cfg_src`. The encodings are: 0 = RGB565 in [15:0]; 1 = RGB666 in [17:0]; 2 = RGB888 in [23:0]. Each channel is expanded to 8 bits by repeating its top bits. The word is then re-encoded according to `cfg_wlen`: 0 = RGB565 in [15:0]; 2 = RGB888 in [23:0]. All other bits are 0.
- R8: With `cfg_rgb`=1 and `cfg_wlen`=1, RGB666 is placed in [31:14] when `cfg_fmt18_hi`=1 and in [17:0] when it is 0. All other bits are 0.
- R9: An `end_txn` pulse with bytes pending emits the partial word with its valid count. With nothing pending, it emits nothing.
- R10: While `out_valid`=1 and `out_ready`=0, `busy`=1, and `out_valid` and `out_data` hold steady.
- R11: `out_valid` rises on the clock edge that captures the completing subword or the `end_txn` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus16 | input | 1 | Subword width: 1 = 16 bits, 0 = 8 bits |
| cfg_pack_cnt | input | 3 | Subwords per output word |
| cfg_dummy | input | DUMMY_W | Leading subwords to discard per transaction |
| cfg_shift_left | input | 1 | Shift direction: 1 = left |
| cfg_shift_amt | input | SHIFT_W | Shift distance in bits |
| cfg_swap | input | 1 | Reverse the valid bytes |
| cfg_rgb | input | 1 | Enable pixel re-encoding |
| cfg_src | input | 2 | Source pixel layout |
| cfg_wlen | input | 2 | Output pixel layout |
| cfg_fmt18_hi | input | 1 | Place 18-bit pixels in the upper bits |
| start | input | 1 | Start-of-transaction pulse |
| end_txn | input | 1 | End-of-transaction pulse; flushes a partial word |
| rd_valid | input | 1 | One subword is present on rd_data |
| rd_data | input | 16 | Read subword |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_bytes | output | 3 | Number of valid bytes in the output word |
| busy | output | 1 | Output stalled; strobes are not accepted |

## Verification
The assertions assume that the configuration inputs stay constant while a word is held at the output. This matters because the zero-upper-bytes check reads `cfg_rgb` at the time the word is presented. The assertions also assume that the strobe source never presents `rd_valid` while `busy` is high. The stimulus changes configuration only between scenarios, when no word is pending. It issues strobes only after the previous word has been accepted, or before the stalled case begins.

// File: rtl/lcd_rd_packer.sv
module lcd_rd_packer #(
  parameter int DUMMY_W = 4,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_bus16,
  input  logic [2:0]         cfg_pack_cnt,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic               cfg_shift_left,
  input  logic [SHIFT_W-1:0] cfg_shift_amt,
  input  logic               cfg_swap,
  input  logic               cfg_rgb,
  input  logic [1:0]         cfg_src,
  input  logic [1:0]         cfg_wlen,
  input  logic               cfg_fmt18_hi,
  input  logic               start,
  input  logic               end_txn,
  input  logic               rd_valid,
  input  logic [15:0]        rd_data,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic [2:0]         out_bytes,
  output logic               busy
);
  localparam int WORD_BYTES = 4;

  logic [31:0]        acc;
  logic [2:0]         nbytes, nsub;
  logic [DUMMY_W-1:0] dummy_left;
  logic [15:0]        sub_in, sub_sh;
  logic [31:0]        merged, pick, sw, rgb;
  logic [2:0]         nb_new, nsub_new, eff_cnt, pick_nb;
  logic [7:0]         r8, g8, b8;

  assign busy     = out_valid && !out_ready;
  wire   take     = rd_valid && !busy && !start;
  wire   capture  = take && (dummy_left == '0);
  wire   discard  = take && (dummy_left != '0);

  assign sub_in   = cfg_bus16 ? rd_data : {8'h00, rd_data[7:0]};
  always_comb begin
    sub_sh = cfg_shift_left ? (sub_in << cfg_shift_amt) : (sub_in >> cfg_shift_amt);
    if (!cfg_bus16) sub_sh[15:8] = 8'h00;
  end

  assign eff_cnt  = (cfg_pack_cnt == 3'd0) ? 3'd1 : cfg_pack_cnt;
  assign merged   = acc | ({16'h0000, sub_sh} << {nbytes[1:0], 3'b000});
  assign nb_new   = nbytes + (cfg_bus16 ? 3'd2 : 3'd1);
  assign nsub_new = nsub + 3'd1;
  wire   full     = (nsub_new >= eff_cnt) || (nb_new >= 3'(WORD_BYTES));
  wire   emit_cap = capture && (full || end_txn);
  wire   flush    = end_txn && !busy && !capture && (nbytes != 3'd0);
  wire   emit     = emit_cap || flush;

  assign pick     = capture ? merged : acc;
  assign pick_nb  = capture ? nb_new : nbytes;

  always_comb begin
    sw = '0;
    for (int i = 0; i < WORD_BYTES; i++)
      if (i < int'(pick_nb))
        sw[8*i +: 8] = cfg_swap ? pick[8*(int'(pick_nb)-1-i) +: 8] : pick[8*i +: 8];
  end

  always_comb begin
    case (cfg_src)
      2'd0: begin
        r8 = {sw[15:11], sw[15:13]};
        g8 = {sw[10:5], sw[10:9]};
        b8 = {sw[4:0], sw[4:2]};
      end
      2'd1: begin
        r8 = {sw[17:12], sw[17:16]};
        g8 = {sw[11:6], sw[11:10]};
        b8 = {sw[5:0], sw[5:4]};
      end
      default: begin
        r8 = sw[23:16];
        g8 = sw[15:8];
        b8 = sw[7:0];
      end
    endcase
    case (cfg_wlen)
      2'd0:    rgb = {16'h0000, r8[7:3], g8[7:2], b8[7:3]};
      2'd1:    rgb = cfg_fmt18_hi ? {r8[7:2], g8[7:2], b8[7:2], 14'h0}
                                  : {14'h0, r8[7:2], g8[7:2], b8[7:2]};
      default: rgb = {8'h00, r8, g8, b8};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_bytes  <= '0;
      acc        <= '0;
      nbytes     <= '0;
      nsub       <= '0;
      dummy_left <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= cfg_rgb ? rgb : sw;
        out_bytes <= pick_nb;
      end
      if (start) begin
        acc        <= '0;
        nbytes     <= '0;
        nsub       <= '0;
        dummy_left <= cfg_dummy;
      end else if (discard) begin
        dummy_left <= dummy_left - 1'b1;
      end else if (emit) begin
        acc    <= '0;
        nbytes <= '0;
        nsub   <= '0;
      end else if (capture) begin
        acc    <= merged;
        nbytes <= nb_new;
        nsub   <= nsub_new;
      end
    end
  end
endmodule

// File: rtl/lcd_rd_packer_chk.sv
module lcd_rd_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_rgb,
  input logic        end_txn,
  input logic        rd_valid,
  input logic        out_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic [2:0]  out_bytes,
  input logic        busy
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !busy));

  a_r3_bytes_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes != 3'd0 && out_bytes <= 3'd4));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_rgb) |-> ((out_data >> {out_bytes, 3'b000}) == 32'h0));

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rd_valid || end_txn));
endmodule

bind lcd_rd_packer lcd_rd_packer_chk i_chk (.*);

// File: tb/test_lcd_rd_packer.sv
module test_lcd_rd_packer;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_bus16 = 0, cfg_shift_left = 0, cfg_swap = 0, cfg_rgb = 0, cfg_fmt18_hi = 0;
  logic [2:0] cfg_pack_cnt = 3'd1;
  logic [3:0] cfg_dummy = 0, cfg_shift_amt = 0;
  logic [1:0] cfg_src = 0, cfg_wlen = 0;
  logic start = 0, end_txn = 0, rd_valid = 0, out_ready = 1;
  logic [15:0] rd_data = 0;
  logic out_valid, busy;
  logic [31:0] out_data;
  logic [2:0] out_bytes;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_rd_packer i_lcd_rd_packer (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [31:0] d, input logic [2:0] nb);
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check({tag, " data"}, out_data, d);
    check({tag, " bytes"}, 32'(out_bytes), 32'(nb));
  endtask

  task automatic setup(input logic b16, input logic [2:0] cnt, input logic [3:0] dum);
    @(negedge clk);
    cfg_bus16 = b16; cfg_pack_cnt = cnt; cfg_dummy = dum;
    cfg_shift_left = 0; cfg_shift_amt = 0; cfg_swap = 0; cfg_rgb = 0;
    cfg_src = 0; cfg_wlen = 0; cfg_fmt18_hi = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic strobe(input logic [15:0] d);
    @(negedge clk);
    rd_valid = 1; rd_data = d;
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic pulse_end;
    @(negedge clk);
    end_txn = 1;
    @(negedge clk);
    end_txn = 0;
  endtask

  task automatic t_reset;
    check("R1 valid in reset", 32'(out_valid), 0);
    check("R1 busy in reset", 32'(busy), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", 32'(out_valid), 0);
  endtask

  task automatic t_pack8;
    setup(0, 3'd4, 0);
    strobe(16'h0011); strobe(16'hFF22); strobe(16'h0033);
    check("R11 no early word", 32'(out_valid), 0);
    strobe(16'h0044);
    check_word("R3 R11 four bytes", 32'h44332211, 3'd4);
    setup(0, 3'd2, 0);
    strobe(16'hFF5A); strobe(16'h00C3);
    check_word("R3 R6 two bytes", 32'h0000C35A, 3'd2);
  endtask

  task automatic t_dummy;
    setup(1, 3'd2, 4'd2);
    strobe(16'hAAAA); strobe(16'hBBBB);
    check("R2 discarded no word", 32'(out_valid), 0);
    strobe(16'h1234); strobe(16'h5678);
    check_word("R2 first word", 32'h56781234, 3'd4);
    strobe(16'h9ABC); strobe(16'hDEF0);
    check_word("R2 no second discard", 32'hDEF09ABC, 3'd4);
  endtask

  task automatic t_shift;
    setup(1, 3'd1, 0);
    cfg_shift_left = 1; cfg_shift_amt = 4;
    strobe(16'h1234);
    check_word("R4 left shift", 32'h00002340, 3'd2);
    setup(0, 3'd1, 0);
    cfg_shift_left = 0; cfg_shift_amt = 3;
    strobe(16'h00F0);
    check_word("R4 right shift", 32'h0000001E, 3'd1);
    setup(0, 3'd1, 0);
    cfg_shift_left = 1; cfg_shift_amt = 4;
    strobe(16'h00F3);
    check_word("R4 left truncates", 32'h00000030, 3'd1);
  endtask

  task automatic t_swap;
    setup(0, 3'd3, 0);
    cfg_swap = 1;
    strobe(16'h0001); strobe(16'h0002); strobe(16'h0003);
    check_word("R5 three-byte swap", 32'h00010203, 3'd3);
    setup(1, 3'd2, 0);
    cfg_swap = 1;
    strobe(16'h1122); strobe(16'h3344);
    check_word("R5 four-byte swap", 32'h22114433, 3'd4);
  endtask

  task automatic t_rgb;
    setup(1, 3'd1, 0);
    cfg_rgb = 1; cfg_src = 0; cfg_wlen = 2;
    strobe(16'hF81F);
    check_word("R7 565 to 888", 32'h00FF00FF, 3'd2);
    cfg_wlen = 0;
    strobe(16'h07E0);
    check_word("R7 565 to 565", 32'h000007E0, 3'd2);
    cfg_wlen = 1; cfg_fmt18_hi = 0;
    strobe(16'hF800);
    check_word("R8 666 low", 32'h0003F000, 3'd2);
    cfg_fmt18_hi = 1;
    strobe(16'hF800);
    check_word("R8 666 high", 32'hFC000000, 3'd2);
    setup(1, 3'd2, 0);
    cfg_rgb = 1; cfg_src = 2; cfg_wlen = 2;
    strobe(16'h3456); strobe(16'h0012);
    check_word("R7 888 to 888", 32'h00123456, 3'd4);
    cfg_wlen = 0;
    strobe(16'h3456); strobe(16'h0012);
    check_word("R7 888 to 565", 32'h000011AA, 3'd4);
  endtask

  task automatic t_flush;
    setup(0, 3'd4, 0);
    pulse_end;
    check("R9 empty flush silent", 32'(out_valid), 0);
    strobe(16'h00AB); strobe(16'h00CD);
    check("R9 partial pending", 32'(out_valid), 0);
    pulse_end;
    check_word("R9 R11 flush partial", 32'h0000CDAB, 3'd2);
  endtask

  task automatic t_stall;
    setup(0, 3'd1, 0);
    out_ready = 0;
    strobe(16'h0077);
    check_word("R10 stalled word", 32'h00000077, 3'd1);
    check("R10 busy", 32'(busy), 1);
    repeat (3) @(negedge clk);
    check_word("R10 held", 32'h00000077, 3'd1);
    check("R10 still busy", 32'(busy), 1);
    out_ready = 1;
    #1 check("R10 busy drops", 32'(busy), 0);
    @(negedge clk);
    check("R10 accepted", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_pack8;
    t_dummy;
    t_shift;
    t_swap;
    t_rgb;
    t_flush;
    t_stall;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule